// File: doc/BRIEF.md
# Register Micro-Operation Unit with Result Skip

This unit carries out one register-to-register micro-operation per clock. A 12-bit operation field picks two of the three 18-bit working registers (A, I, X), an operation to run on them, any subset of the three registers to receive the result, and a set of tests on the result. The tests raise a skip request. Each cycle it delivers the next values of A, I and X, the skip request, and a flag that marks a signed overflow.

All results come from the register values presented in the same cycle. Every output is registered, so the new register values, the skip and the overflow flag appear one clock after the operation field and operands are applied. Some operations have a side effect on the operand they read. Transfer clears its source, and exchange copies the first operand into the second. That side effect is applied first. The result writes selected by the destination mask then override it.

A zero operand-pair code opens a special column. Its upper four rows give constant zero or increment A, I or X by one. Its lower four rows do nothing at all.

Top module: `ralu_top`

## Requirements
- R1: The operation field `uop[11:10]` selects the operand pair: 01 gives left=A, right=I; 10 gives left=X, right=A; 11 gives left=X, right=I. Subtract computes left minus right.
- R2: `uop[9:7]` selects the operation for pairs 01..11: 000 transfer, 001 negate, 010 exchange, 011 subtract, 100 OR, 101 AND, 110 XOR, 111 add. Arithmetic wraps modulo 2^18.
- R3: With `uop[11:10]`=00, `uop[9:7]`=100 gives a zero result, and 101, 110 and 111 give A+1, I+1 and X+1.
- R4: With `uop[11:10]`=00 and `uop[9:7]` in 000..011, no register changes, skip stays 0 and overflow stays 0, whatever the other bits are.
- R5: `uop[6]`, `uop[5]` and `uop[4]` write the result into A, I and X. Any combination, including none, is legal. A register that is neither a destination nor the target of a side effect keeps its value.
- R6: Transfer and negate take the right operand. Transfer also clears the right register unless that register is a destination.
- R7: Exchange gives the old right value as its result and copies the left value into the right register. A destination write to the same register wins, so pair 01 with destination A alone swaps A and I.
- R8: `uop[3]`, `uop[2]`, `uop[1]` and `uop[0]` enable skip tests for a signed result >0, <-1, =0 and =-1. The skip is the OR of the enabled tests.
- R9: Overflow is 1 for a signed overflow on add or subtract, for an increment of 377777 (octal), and for a negate of 400000 (octal). Otherwise it is 0.
- R10: Outputs update one clock after their inputs. A synchronous active-high reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uop | input | 12 | Micro-operation field |
| a_in | input | 18 | Current A value |
| i_in | input | 18 | Current I value |
| x_in | input | 18 | Current X value |
| a_out | output | 18 | Next A value (registered) |
| i_out | output | 18 | Next I value (registered) |
| x_out | output | 18 | Next X value (registered) |
| skip_out | output | 1 | Skip request (registered) |
| ovf_out | output | 1 | Overflow-set flag (registered) |

## Verification
The bench sweeps all 4096 operation codes against operand triples chosen around the signed limits, 0, -1 and -2. This sweep finds a side effect that beats the destination write, which would break the A/I swap, and a transfer that fails to clear, or clears a register it was told to write. It also finds skip tests judged on a register instead of on the result. Any slip on the boundaries of the >0 and <-1 tests shows up at 0, 1, -1 and -2. An overflow sign rule applied to the wrong operand misses the overflows of 377777+1 and -400000. A special row that leaks through as a write or a skip changes registers that must hold.

// File: rtl/ralu_pkg.sv
package ralu_pkg;
  localparam int UOP_W = 12;
  localparam int NREG  = 3;
  localparam int REG_A = 0;
  localparam int REG_I = 1;
  localparam int REG_X = 2;

  typedef enum logic [1:0] {
    PAIR_SPEC = 2'b00,
    PAIR_AI   = 2'b01,
    PAIR_XA   = 2'b10,
    PAIR_XI   = 2'b11
  } pair_e;

  typedef enum logic [2:0] {
    OP_XFER = 3'd0,
    OP_NEG  = 3'd1,
    OP_XCHG = 3'd2,
    OP_SUB  = 3'd3,
    OP_OR   = 3'd4,
    OP_AND  = 3'd5,
    OP_XOR  = 3'd6,
    OP_ADD  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    SRC_A    = 2'd0,
    SRC_I    = 2'd1,
    SRC_X    = 2'd2,
    SRC_ZERO = 2'd3
  } src_e;

  // Decoded micro-operation
  typedef struct packed {
    logic             active;   // 0 for the no-op rows
    logic             special;  // operand-pair code 00
    op_e              op;
    src_e             lsrc;
    src_e             rsrc;
    logic [NREG-1:0]  dest;     // [0]=A [1]=I [2]=X
    logic [3:0]       skip_en;  // [3]>0 [2]<-1 [1]=0 [0]=-1
  } uop_t;
endpackage

// File: rtl/ralu_decode.sv
module ralu_decode
  import ralu_pkg::*;
(
  input  logic [UOP_W-1:0] uop,
  output uop_t             dec
);
  pair_e pair;
  assign pair = pair_e'(uop[11:10]);

  always_comb begin
    dec.active  = 1'b1;
    dec.special = 1'b0;
    dec.op      = op_e'(uop[9:7]);
    dec.lsrc    = SRC_ZERO;
    dec.rsrc    = SRC_ZERO;
    dec.dest    = {uop[4], uop[5], uop[6]};
    dec.skip_en = uop[3:0];
    case (pair)
      PAIR_AI: begin dec.lsrc = SRC_A; dec.rsrc = SRC_I; end
      PAIR_XA: begin dec.lsrc = SRC_X; dec.rsrc = SRC_A; end
      PAIR_XI: begin dec.lsrc = SRC_X; dec.rsrc = SRC_I; end
      default: begin
        dec.special = 1'b1;
        dec.active  = uop[9];
        case (uop[8:7])
          2'b01:   dec.lsrc = SRC_A;
          2'b10:   dec.lsrc = SRC_I;
          2'b11:   dec.lsrc = SRC_X;
          default: dec.lsrc = SRC_ZERO;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/ralu_core.sv
module ralu_core
  import ralu_pkg::*;
#(
  parameter int W = 18
) (
  input  uop_t            dec,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    i,
  input  logic [W-1:0]    x,
  output logic [W-1:0]    res,
  output logic            ovf,
  output logic [NREG-1:0] sec_we,
  output logic [W-1:0]    sec_val
);
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] lv, rv, sum, diff;

  function automatic logic [NREG-1:0] mask_of(input src_e s);
    case (s)
      SRC_A:   mask_of = 3'b001;
      SRC_I:   mask_of = 3'b010;
      SRC_X:   mask_of = 3'b100;
      default: mask_of = 3'b000;
    endcase
  endfunction

  always_comb begin
    case (dec.lsrc)
      SRC_A:   lv = a;
      SRC_I:   lv = i;
      SRC_X:   lv = x;
      default: lv = '0;
    endcase
    case (dec.rsrc)
      SRC_A:   rv = a;
      SRC_I:   rv = i;
      SRC_X:   rv = x;
      default: rv = '0;
    endcase
  end

  assign sum  = lv + rv;
  assign diff = lv - rv;

  always_comb begin
    res     = '0;
    ovf     = 1'b0;
    sec_we  = '0;
    sec_val = '0;
    if (!dec.active) begin
      res = '0;
    end else if (dec.special) begin
      if (dec.lsrc != SRC_ZERO) begin
        res = lv + ONE;
        ovf = (lv == MAXP);
      end
    end else begin
      case (dec.op)
        OP_XFER: begin
          res    = rv;
          sec_we = mask_of(dec.rsrc);
        end
        OP_NEG: begin
          res = -rv;
          ovf = (rv == MINN);
        end
        OP_XCHG: begin
          res     = rv;
          sec_we  = mask_of(dec.rsrc);
          sec_val = lv;
        end
        OP_SUB: begin
          res = diff;
          ovf = (lv[W-1] != rv[W-1]) && (diff[W-1] != lv[W-1]);
        end
        OP_OR:  res = lv | rv;
        OP_AND: res = lv & rv;
        OP_XOR: res = lv ^ rv;
        default: begin
          res = sum;
          ovf = (lv[W-1] == rv[W-1]) && (sum[W-1] != lv[W-1]);
        end
      endcase
    end
  end
endmodule

// File: rtl/ralu_writeback.sv
module ralu_writeback
  import ralu_pkg::*;
#(
  parameter int W = 18
) (
  input  logic            active,
  input  logic [NREG-1:0] dest,
  input  logic [W-1:0]    res,
  input  logic [NREG-1:0] sec_we,
  input  logic [W-1:0]    sec_val,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    i,
  input  logic [W-1:0]    x,
  output logic [W-1:0]    a_n,
  output logic [W-1:0]    i_n,
  output logic [W-1:0]    x_n
);
  logic [W-1:0] cur [NREG];
  logic [W-1:0] nxt [NREG];

  assign cur[REG_A] = a;
  assign cur[REG_I] = i;
  assign cur[REG_X] = x;

  // Destination write has priority over the side-effect write
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    assign nxt[k] = (active && dest[k]) ? res :
                    sec_we[k]           ? sec_val : cur[k];
  end

  assign a_n = nxt[REG_A];
  assign i_n = nxt[REG_I];
  assign x_n = nxt[REG_X];
endmodule

// File: rtl/ralu_skip.sv
module ralu_skip #(
  parameter int W = 18
) (
  input  logic         active,
  input  logic [3:0]   skip_en,
  input  logic [W-1:0] res,
  output logic         skip
);
  logic is_zero, is_m1, is_pos, is_ltm1;

  assign is_zero = (res == '0);
  assign is_m1   = &res;
  assign is_pos  = !res[W-1] && !is_zero;
  assign is_ltm1 = res[W-1] && !is_m1;

  assign skip = active && |(skip_en & {is_pos, is_ltm1, is_zero, is_m1});
endmodule

// File: rtl/ralu_top.sv
module ralu_top
  import ralu_pkg::*;
#(
  parameter int W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [UOP_W-1:0] uop,
  input  logic [W-1:0]     a_in,
  input  logic [W-1:0]     i_in,
  input  logic [W-1:0]     x_in,
  output logic [W-1:0]     a_out,
  output logic [W-1:0]     i_out,
  output logic [W-1:0]     x_out,
  output logic             skip_out,
  output logic             ovf_out
);
  uop_t            dec;
  logic [W-1:0]    res, sec_val, a_n, i_n, x_n;
  logic [NREG-1:0] sec_we;
  logic            ovf, skip;

  ralu_decode u_dec (.uop(uop), .dec(dec));

  ralu_core #(.W(W)) u_core (
    .dec(dec), .a(a_in), .i(i_in), .x(x_in),
    .res(res), .ovf(ovf), .sec_we(sec_we), .sec_val(sec_val)
  );

  ralu_writeback #(.W(W)) u_wb (
    .active(dec.active), .dest(dec.dest), .res(res),
    .sec_we(sec_we), .sec_val(sec_val),
    .a(a_in), .i(i_in), .x(x_in),
    .a_n(a_n), .i_n(i_n), .x_n(x_n)
  );

  ralu_skip #(.W(W)) u_skip (
    .active(dec.active), .skip_en(dec.skip_en), .res(res), .skip(skip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out    <= '0;
      i_out    <= '0;
      x_out    <= '0;
      skip_out <= 1'b0;
      ovf_out  <= 1'b0;
    end else begin
      a_out    <= a_n;
      i_out    <= i_n;
      x_out    <= x_n;
      skip_out <= skip;
      ovf_out  <= ovf;
    end
  end
endmodule

// File: rtl/ralu_chk.sv
module ralu_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [11:0]  uop,
  input logic [W-1:0] a_in,
  input logic [W-1:0] i_in,
  input logic [W-1:0] x_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] i_out,
  input logic [W-1:0] x_out,
  input logic         skip_out,
  input logic         ovf_out
);
  logic         live, rst_d;
  logic [11:0]  p_uop;
  logic [W-1:0] p_a, p_i, p_x;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    live  <= !rst;
    p_uop <= uop;
    p_a   <= a_in;
    p_i   <= i_in;
    p_x   <= x_in;
  end

  always_ff @(posedge clk) begin
    if (rst_d === 1'b1) begin
      assert_reset_zero_R10: assert (a_out == '0 && i_out == '0 && x_out == '0
                                     && !skip_out && !ovf_out);
    end
  end

  assert_nop_rows_R4: assert property (@(posedge clk) disable iff (rst)
    (live && p_uop[11:10] == 2'b00 && !p_uop[9]) |->
      (a_out == p_a && i_out == p_i && x_out == p_x && !skip_out && !ovf_out));

  assert_skip_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
    (live && p_uop[3:0] == 4'b0000) |-> !skip_out);

  assert_logic_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (live && p_uop[11:10] != 2'b00 &&
     (p_uop[9:7] == 3'b000 || p_uop[9:7] == 3'b010 || p_uop[9:7] == 3'b100 ||
      p_uop[9:7] == 3'b101 || p_uop[9:7] == 3'b110)) |-> !ovf_out);

  assert_swap_ai_R7: assert property (@(posedge clk) disable iff (rst)
    (live && p_uop[11:7] == 5'b01010 && p_uop[6:4] == 3'b100) |->
      (a_out == p_i && i_out == p_a && x_out == p_x));

  assert_no_dest_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (live && p_uop[11:10] != 2'b00 && p_uop[6:4] == 3'b000 &&
     p_uop[9:7] != 3'b000 && p_uop[9:7] != 3'b010) |->
      (a_out == p_a && i_out == p_i && x_out == p_x));
endmodule

bind ralu_top ralu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .uop(uop),
  .a_in(a_in), .i_in(i_in), .x_in(x_in),
  .a_out(a_out), .i_out(i_out), .x_out(x_out),
  .skip_out(skip_out), .ovf_out(ovf_out)
);

// File: tb/sim_ralu_top.sv
`timescale 1ns/1ps
module sim_ralu_top;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [11:0]  uop = '0;
  logic [W-1:0] a_in = '0, i_in = '0, x_in = '0;
  logic [W-1:0] a_out, i_out, x_out;
  logic         skip_out, ovf_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ralu_top #(.W(W)) u0 (
    .clk(clk), .rst(rst), .uop(uop), .a_in(a_in), .i_in(i_in), .x_in(x_in),
    .a_out(a_out), .i_out(i_out), .x_out(x_out),
    .skip_out(skip_out), .ovf_out(ovf_out)
  );

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s uop=%h actual=%h expected=%h", tag, what, uop, act, exp);
    end
  endtask

  function automatic int sv(input logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  // Reference model written from the requirements
  task automatic model(input logic [11:0] u, input logic [W-1:0] a, i, x,
                       output logic [W-1:0] ea, ei, ex,
                       output logic es, output logic eo);
    logic [W-1:0] regs [3];
    logic [W-1:0] l, r, res;
    int           rk, lk, ri, rs;
    bit           act, arith;
    regs[0] = a; regs[1] = i; regs[2] = x;
    act = 1'b1; arith = 1'b0; ri = 0; res = '0; eo = 1'b0;
    if (u[11:10] == 2'b00) begin
      if (u[9] == 1'b0) act = 1'b0;
      else if (u[8:7] == 2'b00) res = '0;
      else begin
        lk = int'(u[8:7]) - 1;
        ri = sv(regs[lk]) + 1;
        arith = 1'b1;
      end
    end else begin
      lk = (u[11:10] == 2'b01) ? 0 : 2;
      rk = (u[11:10] == 2'b10) ? 0 : 1;
      l = regs[lk]; r = regs[rk];
      case (u[9:7])
        3'd0: begin res = r; regs[rk] = '0; end
        3'd1: begin ri = -sv(r); arith = 1'b1; end
        3'd2: begin res = r; regs[rk] = l; end
        3'd3: begin ri = sv(l) - sv(r); arith = 1'b1; end
        3'd4: res = l | r;
        3'd5: res = l & r;
        3'd6: res = l ^ r;
        default: begin ri = sv(l) + sv(r); arith = 1'b1; end
      endcase
    end
    if (arith) begin
      res = ri[W-1:0];
      eo  = (ri > 131071) || (ri < -131072);
    end
    es = 1'b0;
    if (act) begin
      if (u[6]) regs[0] = res;
      if (u[5]) regs[1] = res;
      if (u[4]) regs[2] = res;
      rs = sv(res);
      es = (u[3] && rs > 0) || (u[2] && rs < -1) || (u[1] && rs == 0) || (u[0] && rs == -1);
    end
    ea = regs[0]; ei = regs[1]; ex = regs[2];
  endtask

  function automatic string tag_of(input logic [11:0] u);
    if (u[11:10] == 2'b00) return u[9] ? "R3" : "R4";
    case (u[9:7])
      3'd0, 3'd1: return "R6";
      3'd2:       return "R7";
      default:    return "R2";
    endcase
  endfunction

  task automatic apply(input logic [11:0] u, input logic [W-1:0] a, i, x);
    @(negedge clk);
    uop = u; a_in = a; i_in = i; x_in = x;
    @(posedge clk);
    #1;
  endtask

  task automatic sweep_check(input logic [W-1:0] a, i, x);
    logic [W-1:0] ea, ei, ex;
    logic es, eo;
    for (int u = 0; u < 4096; u++) begin
      apply(12'(u), a, i, x);
      model(12'(u), a, i, x, ea, ei, ex, es, eo);
      chk(tag_of(12'(u)), "A", a_out, ea);
      chk(tag_of(12'(u)), "I", i_out, ei);
      chk(tag_of(12'(u)), "X", x_out, ex);
      chk("R8", "skip", {17'd0, skip_out}, {17'd0, es});
      chk("R9", "ovf", {17'd0, ovf_out}, {17'd0, eo});
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] vals [8];
    logic [W-1:0] s;
    vals[0] = 18'h00000; vals[1] = 18'h00001; vals[2] = 18'h3FFFF; vals[3] = 18'h3FFFE;
    vals[4] = 18'h1FFFF; vals[5] = 18'h20000; vals[6] = 18'h00005; vals[7] = 18'h2AAAA;

    // R10: reset clears outputs even with live inputs
    uop = 12'h4E0; a_in = 18'h12345; i_in = 18'h00777; x_in = 18'h00042;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "reset A", a_out, '0);
    chk("R10", "reset I", i_out, '0);
    chk("R10", "reset X", x_out, '0);
    chk("R10", "reset skip", {17'd0, skip_out}, '0);
    @(negedge clk); rst = 1'b0;

    // R1: pair 10, subtract: X - A into A
    apply(12'h9C0, 18'd10, 18'd0, 18'd3);
    chk("R1", "X-A", a_out, 18'h3FFF9);
    // R5: OR into I and X, A held
    apply(12'h630, 18'h0000F, 18'h000F0, 18'h00000);
    chk("R5", "A held", a_out, 18'h0000F);
    chk("R5", "I dest", i_out, 18'h000FF);
    chk("R5", "X dest", x_out, 18'h000FF);
    // R7: exchange with A destination swaps A and I
    apply(12'h540, 18'd123, 18'd456, 18'd789);
    chk("R7", "swap A", a_out, 18'd456);
    chk("R7", "swap I", i_out, 18'd123);
    chk("R7", "swap X", x_out, 18'd789);
    // R6: transfer clears source, unless also destination
    apply(12'h440, 18'd7, 18'd9, 18'd1);
    chk("R6", "xfer A", a_out, 18'd9);
    chk("R6", "xfer clears I", i_out, 18'd0);
    apply(12'h460, 18'd7, 18'd9, 18'd1);
    chk("R6", "xfer keeps I", i_out, 18'd9);
    // R9: step of max positive and negate of min negative
    apply(12'h2C0, 18'h1FFFF, 18'd0, 18'd0);
    chk("R9", "step A", a_out, 18'h20000);
    chk("R9", "step ovf", {17'd0, ovf_out}, 18'd1);
    apply(12'h4A0, 18'd0, 18'h20000, 18'd0);
    chk("R9", "neg I", i_out, 18'h20000);
    chk("R9", "neg ovf", {17'd0, ovf_out}, 18'd1);
    // R8: zero test on a result with no destination
    apply(12'h602, 18'd0, 18'd0, 18'd5);
    chk("R8", "skip on zero", {17'd0, skip_out}, 18'd1);
    chk("R8", "X held", x_out, 18'd5);
    // R3: zero row clears all destinations
    apply(12'h270, 18'd1, 18'd2, 18'd3);
    chk("R3", "zero A", a_out, '0);
    chk("R3", "zero X", x_out, '0);
    // R4: no-op row with every other bit set
    apply(12'h1FF, 18'd1, 18'd2, 18'd3);
    chk("R4", "nop I", i_out, 18'd2);
    chk("R4", "nop skip", {17'd0, skip_out}, '0);

    // R2 and all others: full sweep of the operation field
    for (int t = 0; t < 8; t++)
      sweep_check(vals[t], vals[(t + 3) % 8], vals[(t + 5) % 8]);
    s = 18'h1234B;
    for (int t = 0; t < 4; t++) begin
      logic [W-1:0] p, q, r;
      s = s * 18'd1103 + 18'd12345; p = s;
      s = s * 18'd1103 + 18'd12345; q = s;
      s = s * 18'd1103 + 18'd12345; r = s;
      sweep_check(p, q, r);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule